// File: doc/BRIEF.md
# Line-Delay FIFO Sequencer

This block produces the write and read strobes for a FIFO that holds one line of video, so that the FIFO output is the input stream delayed by exactly one line. It receives a frame-active level and a line-active level, both sampled on the pixel clock. It stores every line of a frame. From the second line onward, it replays the previously stored line while the current line is being written. Reads therefore start on the same line edge as writes, and the FIFO drains as fast as it fills.

After reset the sequencer stays disarmed until it has seen the frame-active input low. This means capture never starts partway through a frame. A data-present register stands in for a FIFO empty flag. It is set by writing and is cleared whenever the frame-active input is low, so the first line of every frame only fills the FIFO. A valid flag follows the read strobe by the FIFO's read latency, so that it lines up with the FIFO's output data.

Top module: `line_delay_seq`

## Requirements
- R1: When the line input goes from low to high while the frame input is high and the block is armed, `wr_en` rises one clock after the first high sample of the line.
- R2: Once started, `wr_en` and `rd_en` stay high for as long as the line input stays high. Both fall one clock after the first low sample of the line input.
- R3: The first stored line of a frame produces writes only: `rd_en` stays low for that whole line.
- R4: Every later line of the same frame asserts `rd_en` in exactly the same cycles as `wr_en`.
- R5: A low frame input clears the data-present state, so the first line of the next frame is again write-only.
- R6: After reset, no write occurs until the frame input has been sampled low at least once. A line that lies inside a frame already running at reset is ignored.
- R7: `rd_vld` equals `rd_en` delayed by `RD_LAT` clocks (default 1).
- R8: The reset input is synchronous and active high. One clock after it is sampled high, all outputs are low, even in the middle of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Frame-active level |
| line_in | input | 1 | Line-active level |
| wr_en | output | 1 | FIFO write strobe |
| rd_en | output | 1 | FIFO read strobe |
| rd_vld | output | 1 | Marks valid data at the FIFO output |

## Verification
The bench opens with a line inside a frame that was already running when reset ended. A sequencer that arms without first seeing frame low would write that partial frame. It then runs two frames of several lines each. A design that waits one line too long to start reading shows rd_en missing on line two. A design that forgets to clear data-present at frame end reads on the first line of the second frame. Valid-flag timing is compared every cycle, which catches a flag that is not delayed or is delayed twice. A reset in the middle of a line checks that the strobes drop at once and that the block disarms again.

// File: rtl/line_delay_pkg.sv
package line_delay_pkg;
  localparam int unsigned DEF_RD_LAT = 1;

  typedef struct packed {
    logic wr;
    logic rd;
  } strobe_t;
endpackage

// File: rtl/lds_edge_arm.sv
// Line rising-edge detection and post-reset arming on frame low.
module lds_edge_arm (
  input  logic clk,
  input  logic rst,
  input  logic frame_in,
  input  logic line_in,
  output logic start,
  output logic armed
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      line_q <= line_in;
      if (!frame_in) armed <= 1'b1;
    end
  end

  assign start = line_in & ~line_q & frame_in & armed;

  // R6
  no_start_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && frame_in) |=> !$past(start));
endmodule

// File: rtl/lds_strobe_gen.sv
// Write/read strobe generation with data-present tracking.
module lds_strobe_gen
  import line_delay_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    frame_in,
  input  logic    line_in,
  input  logic    start,
  output strobe_t stb
);
  logic present;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb     <= '0;
      present <= 1'b0;
    end else begin
      stb.wr <= line_in & (stb.wr | start);
      stb.rd <= line_in & (stb.rd | (start & present));
      if (!frame_in)   present <= 1'b0;
      else if (stb.wr) present <= 1'b1;
    end
  end

  // R2
  wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !line_in |=> !stb.wr && !stb.rd);
  // R4
  rd_with_wr_chk: assert property (@(posedge clk) disable iff (rst)
    stb.rd |-> stb.wr);
  // R1
  wr_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stb.wr) |-> $past(line_in && frame_in));
endmodule

// File: rtl/lds_valid_pipe.sv
// Delays the read strobe by the FIFO read latency.
module lds_valid_pipe #(
  parameter int unsigned LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [LAT-1:0] sr;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[LAT-2:0], d};
      end
    end
  endgenerate

  assign q = sr[LAT-1];
endmodule

// File: rtl/line_delay_seq.sv
module line_delay_seq
  import line_delay_pkg::*;
#(
  parameter int unsigned RD_LAT = DEF_RD_LAT
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_in,
  input  logic line_in,
  output logic wr_en,
  output logic rd_en,
  output logic rd_vld
);
  logic    start;
  logic    armed;
  strobe_t stb;

  lds_edge_arm u_arm (
    .clk(clk), .rst(rst), .frame_in(frame_in), .line_in(line_in),
    .start(start), .armed(armed)
  );

  lds_strobe_gen u_stb (
    .clk(clk), .rst(rst), .frame_in(frame_in), .line_in(line_in),
    .start(start), .stb(stb)
  );

  lds_valid_pipe #(.LAT(RD_LAT)) u_vld (
    .clk(clk), .rst(rst), .d(stb.rd), .q(rd_vld)
  );

  assign wr_en = stb.wr;
  assign rd_en = stb.rd;

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !wr_en && !rd_en && !rd_vld);

  generate
    if (RD_LAT == 1) begin : g_vchk
      // R7
      vld_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rd_vld == $past(rd_en));
    end
  endgenerate
endmodule

// File: tb/line_delay_seq_tb.sv
module line_delay_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic wr;
    logic rd;
    logic vld;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_in = 1'b0;
  logic line_in = 1'b0;
  logic wr_en, rd_en, rd_vld;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;
  exp_t q[$];

  // model state, line granularity
  bit m_armed = 0, m_present = 0, m_prev_l = 0, m_wr = 0, m_rd = 0, m_prd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_delay_seq u_dut (
    .clk(clk), .rst(rst), .frame_in(frame_in), .line_in(line_in),
    .wr_en(wr_en), .rd_en(rd_en), .rd_vld(rd_vld)
  );

  task automatic drive(input bit r, input bit f, input bit l, input string tag);
    exp_t e;
    bit begin_line;
    @(negedge clk);
    rst = r; frame_in = f; line_in = l;
    if (r) begin
      m_armed = 0; m_present = 0; m_prev_l = 0; m_wr = 0; m_rd = 0; m_prd = 0;
      e.wr = 0; e.rd = 0; e.vld = 0;
    end else begin
      begin_line = l && !m_prev_l && f && m_armed;
      if (begin_line) begin m_wr = 1; m_rd = m_present; end
      if (!l) begin m_wr = 0; m_rd = 0; end
      e.wr = m_wr; e.rd = m_rd; e.vld = m_prd;
      m_prd = m_rd;
      if (!f) begin m_armed = 1; m_present = 0; end
      else if (m_wr) m_present = 1;
      m_prev_l = l;
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input bit f, input string tag);
    for (int i = 0; i < n; i++) drive(0, f, 0, tag);
  endtask

  task automatic send_line(input int len, input string tag);
    for (int i = 0; i < len; i++) drive(0, 1, 1, tag);
    idle(3, 1, tag);
  endtask

  // monitor: compares one queued item after each active edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_tests++;
      if (wr_en !== e.wr || rd_en !== e.rd || rd_vld !== e.vld) begin
        n_fail++;
        $display("FAIL %s t=%0t wr/rd/vld actual %b%b%b expected %b%b%b",
                 e.tag, $time, wr_en, rd_en, rd_vld, e.wr, e.rd, e.vld);
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) drive(1, 0, 0, "R8 reset state");
    // R6: frame running at reset, never seen low: line ignored
    idle(2, 1, "R6");
    send_line(6, "R6 unarmed line");
    // arm, then frame of three lines
    idle(3, 0, "R6 frame low");
    idle(2, 1, "R1");
    send_line(5, "R1 R3 first line write-only");
    send_line(5, "R2 R4 R7 second line");
    send_line(4, "R4 R7 third line");
    // R5: frame end clears data-present
    idle(2, 0, "R5 frame gap");
    idle(1, 1, "R5");
    send_line(4, "R5 new frame first line");
    send_line(7, "R4 R2 long line");
    // R8: reset mid-line, then disarmed again
    drive(0, 1, 1, "R8 pre");
    drive(0, 1, 1, "R8 pre");
    drive(0, 1, 1, "R8 pre");
    drive(1, 1, 1, "R8 reset mid-line");
    drive(1, 1, 1, "R8 reset mid-line");
    drive(0, 1, 0, "R8 after");
    send_line(4, "R6 after reset unarmed");
    idle(2, 0, "R6 rearm");
    send_line(3, "R1 rearmed");
    send_line(3, "R4 rearmed read");
    idle(3, 1, "R7 tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual not finished, expected done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule